// File: doc/BRIEF.md
# Register Pair Transfer Unit

This block holds the six general byte registers of a small 8-bit datapath, grouped as the pairs BC, DE and HL, together with a 16-bit stack pointer. It carries out all operations that treat those registers as 16-bit quantities: load of a 16-bit constant into a pair, increment and decrement of a pair, a 16-bit add of a pair into HL, an exchange of HL with DE, direct store and load of HL through memory, and indirect load and store of the accumulator using BC or DE as the address.

Memory is reached over a byte-wide port with a single-cycle read latency, so every 16-bit memory transfer is split into two back-to-back byte cycles, low byte first at the lower address. The accumulator and the flag register live elsewhere. The unit takes the accumulator value as an input and returns a loaded byte with a write strobe. It touches only the carry flag, again through a value and a write strobe. A command is given as an op code, a pair select and a 16-bit immediate with a one-cycle start. `done` pulses once when the command has finished. Start is ignored until the unit is idle again.

Top module: `pair_xfer_unit`

## Requirements
- R1: After reset all four pairs read zero, and `done`, `mem_we`, `mem_re`, `acc_ld_we` and `cy_we` are low.
- R2: Op code 0 writes `imm` into the pair chosen by `psel` (0 = BC, 1 = DE, 2 = HL, 3 = SP), with `imm[15:8]` landing in the first-named register (B, D, H or the upper SP byte); the other pairs keep their values.
- R3: Op code 1 stores HL at address `imm`. L is written to `imm` in one cycle and H is written to `imm`+1 (mod 2^16) in the next cycle. These are the only two cycles with `mem_we` high.
- R4: Op code 2 loads HL from address `imm`. L gets the byte read at `imm` and H gets the byte read at `imm`+1 (mod 2^16).
- R5: Op code 3 with `psel` 0 or 1 reads the byte at the address held in BC or DE. It returns that byte on `acc_ld_data` with `acc_ld_we` high in the `done` cycle and leaves every pair unchanged.
- R6: Op code 4 with `psel` 0 or 1 performs exactly one write of `acc_in`, as sampled with `start`, to the address held in BC or DE.
- R7: Op codes 3 and 4 with `psel` 2 or 3 make no memory access, raise neither strobe, change no pair and still complete with `done`.
- R8: Op code 5 swaps HL with DE in one operation (HL=4500h, DE=4531h become HL=4531h, DE=4500h). BC and SP do not change.
- R9: Op code 6 sets HL to (HL + selected pair) mod 2^16. `cy_we` is high only in its `done` cycle, and `cy_val` then shows the carry out of bit 15. `psel` 2 doubles HL.
- R10: Op codes 7 and 8 add or subtract one on the selected pair, including SP, and wrap modulo 2^16. They never raise `cy_we`.
- R11: `done` is high for exactly one cycle. Counting the clock edge that samples `start` as edge 1, it is high after edge 2 for op codes 0, 5, 6, 7 and 8, for op code 4, for invalid indirect forms and for unused codes. It is high after edge 3 for op codes 1 and 3, and after edge 4 for op code 2.
- R12: `start` and the command fields are ignored from the sampling edge until `done` has fallen. Unused op codes 9 to 15 complete as no-ops with no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, sampled when idle |
| op | input | 4 | Operation code |
| psel | input | 2 | Pair select: 0 BC, 1 DE, 2 HL, 3 SP |
| imm | input | 16 | Immediate constant or direct address |
| acc_in | input | 8 | Accumulator value for indirect store |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| done | output | 1 | One-cycle completion pulse |
| acc_ld_we | output | 1 | Accumulator load strobe |
| acc_ld_data | output | 8 | Byte for the accumulator |
| cy_we | output | 1 | Carry flag write strobe |
| cy_val | output | 1 | Carry flag value |
| pair_bc | output | 16 | BC contents |
| pair_de | output | 16 | DE contents |
| pair_hl | output | 16 | HL contents |
| pair_sp | output | 16 | Stack pointer contents |

## Verification
The hardest case to reach from the ports is a competing command arriving while a multi-cycle operation is still in progress. The stimulus keeps `start` high and swaps in a load-immediate command with a different constant and accumulator value from the cycle after sampling until `done`. The bench then checks that the original command finished with its original operands and that the competing constant appears in no pair. Direct transfers are also run at address FFFFh, so that the high byte must wrap to 0000h, and add and step sweeps cover the carry and wrap edges on every pair, SP included.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

  localparam int OPW   = 4;
  localparam int SELW  = 2;
  localparam int NPAIR = 1 << SELW;

  typedef enum logic [OPW-1:0] {
    OP_LDIMM = 4'd0,
    OP_STHL  = 4'd1,
    OP_LDHL  = 4'd2,
    OP_LDIND = 4'd3,
    OP_STIND = 4'd4,
    OP_SWAP  = 4'd5,
    OP_ADDHL = 4'd6,
    OP_INC   = 4'd7,
    OP_DEC   = 4'd8
  } op_e;

  typedef enum logic [SELW-1:0] {
    PR_BC = 2'd0,
    PR_DE = 2'd1,
    PR_HL = 2'd2,
    PR_SP = 2'd3
  } pair_e;

  typedef enum logic [2:0] {
    S_IDLE, S_EXEC, S_WR0, S_WR1, S_RD0, S_RD1, S_CAP, S_DONE
  } st_e;

  typedef enum logic [1:0] {
    AR_ADD, AR_INC, AR_DEC
  } ar_e;

endpackage

// File: rtl/pxu_arith.sv
module pxu_arith
  import pxu_pkg::*;
#(
  parameter int PW = 16
) (
  input  ar_e           mode,
  input  logic [PW-1:0] opa,
  input  logic [PW-1:0] opb,
  output logic [PW-1:0] res,
  output logic          carry
);

  logic [PW:0] ext;

  always_comb begin
    case (mode)
      AR_INC:  ext = {1'b0, opa} + (PW+1)'(1);
      AR_DEC:  ext = {1'b0, opa} - (PW+1)'(1);
      default: ext = {1'b0, opa} + {1'b0, opb};
    endcase
    res   = ext[PW-1:0];
    carry = (mode == AR_ADD) ? ext[PW] : 1'b0;
  end

endmodule

// File: rtl/pxu_bank.sv
module pxu_bank
  import pxu_pkg::*;
#(
  parameter int DW = 8,
  localparam int PW = 2 * DW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pw_en,
  input  logic [SELW-1:0]           pw_sel,
  input  logic [PW-1:0]             pw_val,
  input  logic                      swap_en,
  input  logic                      lo_en,
  input  logic                      hi_en,
  input  logic [DW-1:0]             byte_val,
  output logic [NPAIR-1:0][PW-1:0]  pr_q
);

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    localparam logic [SELW-1:0] ME = SELW'(g);
    logic [PW-1:0] q;
    logic [PW-1:0] nx;
    logic          en;

    always_comb begin
      nx = q;
      en = 1'b0;
      if (pw_en && (pw_sel == ME)) begin
        nx = pw_val;
        en = 1'b1;
      end
      if (swap_en && (ME == PR_DE)) begin
        nx = pr_q[PR_HL];
        en = 1'b1;
      end
      if (swap_en && (ME == PR_HL)) begin
        nx = pr_q[PR_DE];
        en = 1'b1;
      end
      if (lo_en && (ME == PR_HL)) begin
        nx = {q[PW-1:DW], byte_val};
        en = 1'b1;
      end
      if (hi_en && (ME == PR_HL)) begin
        nx = {byte_val, q[DW-1:0]};
        en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= nx;
    end

    assign pr_q[g] = q;
  end

  // R8: exchange moves both pairs at the same edge
  assert_swap_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swap_en |=> (pr_q[PR_HL] == $past(pr_q[PR_DE])) && (pr_q[PR_DE] == $past(pr_q[PR_HL])));

  // R4: low byte capture leaves the high byte of HL untouched
  assert_lo_keeps_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_en && !hi_en) |=> (pr_q[PR_HL][DW-1:0] == $past(byte_val)) &&
                         (pr_q[PR_HL][PW-1:DW] == $past(pr_q[PR_HL][PW-1:DW])));

endmodule

// File: rtl/pxu_seq.sv
module pxu_seq
  import pxu_pkg::*;
#(
  parameter int DW = 8,
  localparam int PW = 2 * DW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [OPW-1:0]            op_i,
  input  logic [SELW-1:0]           psel_i,
  input  logic [PW-1:0]             imm_i,
  input  logic [DW-1:0]             acc_i,
  input  logic [DW-1:0]             mem_rdata,
  input  logic [NPAIR-1:0][PW-1:0]  pr_q,
  output logic [PW-1:0]             mem_addr,
  output logic [DW-1:0]             mem_wdata,
  output logic                      mem_we,
  output logic                      mem_re,
  output logic                      done,
  output logic                      acc_ld_we,
  output logic [DW-1:0]             acc_ld_data,
  output logic                      cy_we,
  output logic                      cy_val,
  output logic                      pw_en,
  output logic [SELW-1:0]           pw_sel,
  output logic [PW-1:0]             pw_val,
  output logic                      swap_en,
  output logic                      lo_en,
  output logic                      hi_en,
  output logic [DW-1:0]             byte_val
);

  st_e             st_q, st_d;
  logic [OPW-1:0]  op_q;
  logic [SELW-1:0] sel_q;
  logic [PW-1:0]   imm_q;
  logic [DW-1:0]   accin_q;
  logic [DW-1:0]   accld_q, accld_d;
  logic            cy_q, cy_d;
  logic            cmd_ld;
  logic            ind_ok_i, ind_ok_q;
  logic            direct_q;
  logic            in_exec;

  ar_e             ar_mode;
  logic [PW-1:0]   ar_a, ar_b, ar_res;
  logic            ar_c;

  assign ind_ok_i = (psel_i == PR_BC) || (psel_i == PR_DE);
  assign ind_ok_q = (sel_q  == PR_BC) || (sel_q  == PR_DE);
  assign direct_q = (op_q == OP_STHL) || (op_q == OP_LDHL);
  assign cmd_ld   = (st_q == S_IDLE) && start;
  assign in_exec  = (st_q == S_EXEC);

  // next state
  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          case (op_i)
            OP_STHL:  st_d = S_WR0;
            OP_LDHL:  st_d = S_RD0;
            OP_STIND: st_d = ind_ok_i ? S_WR0 : S_EXEC;
            OP_LDIND: st_d = ind_ok_i ? S_RD0 : S_EXEC;
            default:  st_d = S_EXEC;
          endcase
        end
      end
      S_EXEC:  st_d = S_DONE;
      S_WR0:   st_d = (op_q == OP_STHL) ? S_WR1 : S_DONE;
      S_WR1:   st_d = S_DONE;
      S_RD0:   st_d = (op_q == OP_LDHL) ? S_RD1 : S_CAP;
      S_RD1:   st_d = S_CAP;
      S_CAP:   st_d = S_DONE;
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  // command capture, enabled only when idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      sel_q   <= '0;
      imm_q   <= '0;
      accin_q <= '0;
    end else if (cmd_ld) begin
      op_q    <= op_i;
      sel_q   <= psel_i;
      imm_q   <= imm_i;
      accin_q <= acc_i;
    end
  end

  // 16-bit arithmetic
  always_comb begin
    case (op_q)
      OP_INC:  ar_mode = AR_INC;
      OP_DEC:  ar_mode = AR_DEC;
      default: ar_mode = AR_ADD;
    endcase
    ar_a = (op_q == OP_ADDHL) ? pr_q[PR_HL] : pr_q[sel_q];
    ar_b = pr_q[sel_q];
  end

  pxu_arith #(.PW(PW)) u_arith (
    .mode  (ar_mode),
    .opa   (ar_a),
    .opb   (ar_b),
    .res   (ar_res),
    .carry (ar_c)
  );

  // bank write controls
  always_comb begin
    pw_en    = in_exec && ((op_q == OP_LDIMM) || (op_q == OP_ADDHL) ||
                           (op_q == OP_INC)   || (op_q == OP_DEC));
    pw_sel   = (op_q == OP_ADDHL) ? PR_HL : sel_q;
    pw_val   = (op_q == OP_LDIMM) ? imm_q : ar_res;
    swap_en  = in_exec && (op_q == OP_SWAP);
    lo_en    = (st_q == S_RD1);
    hi_en    = (st_q == S_CAP) && (op_q == OP_LDHL);
    byte_val = mem_rdata;
  end

  // flag and accumulator side registers
  always_comb begin
    cy_d    = cy_q;
    accld_d = accld_q;
    if (in_exec && (op_q == OP_ADDHL))          cy_d    = ar_c;
    if ((st_q == S_CAP) && (op_q == OP_LDIND))  accld_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_q    <= 1'b0;
      accld_q <= '0;
    end else begin
      cy_q    <= cy_d;
      accld_q <= accld_d;
    end
  end

  // memory port
  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (st_q)
      S_WR0, S_RD0: mem_addr = direct_q ? imm_q : pr_q[sel_q];
      S_WR1, S_RD1: mem_addr = imm_q + PW'(1);
      default:      mem_addr = '0;
    endcase
    case (st_q)
      S_WR0:   mem_wdata = (op_q == OP_STHL) ? pr_q[PR_HL][DW-1:0] : accin_q;
      S_WR1:   mem_wdata = pr_q[PR_HL][PW-1:DW];
      default: mem_wdata = '0;
    endcase
  end

  assign mem_we      = (st_q == S_WR0) || (st_q == S_WR1);
  assign mem_re      = (st_q == S_RD0) || (st_q == S_RD1);
  assign done        = (st_q == S_DONE);
  assign acc_ld_we   = done && (op_q == OP_LDIND) && ind_ok_q;
  assign acc_ld_data = accld_q;
  assign cy_we       = done && (op_q == OP_ADDHL);
  assign cy_val      = cy_q;

  // R3: high byte write follows the low byte at the next address
  assert_hi_follows_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WR1) |-> $past(mem_we) && (mem_addr == $past(mem_addr) + PW'(1)));

  // R4: second read address is one above the first
  assert_rd_next_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RD1) |-> $past(mem_re) && (mem_addr == $past(mem_addr) + PW'(1)));

  // R10: increment lands one above the previous pair value
  assert_inc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && (op_q == OP_INC)) |=> (pr_q[sel_q] == $past(pr_q[sel_q]) + PW'(1)));

  // R11: completion is a single-cycle pulse
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: command fields hold while busy
  assert_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) |=> $stable(op_q) && $stable(imm_q) && $stable(sel_q) && $stable(accin_q));

  // R7: no memory access outside the memory states
  assert_quiet_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_IDLE) || (st_q == S_EXEC) || done) |-> !mem_we && !mem_re);

endmodule

// File: rtl/pair_xfer_unit.sv
module pair_xfer_unit
  import pxu_pkg::*;
#(
  parameter int DW = 8,
  localparam int PW = 2 * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [OPW-1:0]  op,
  input  logic [SELW-1:0] psel,
  input  logic [PW-1:0]   imm,
  input  logic [DW-1:0]   acc_in,
  input  logic [DW-1:0]   mem_rdata,
  output logic [PW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  output logic            done,
  output logic            acc_ld_we,
  output logic [DW-1:0]   acc_ld_data,
  output logic            cy_we,
  output logic            cy_val,
  output logic [PW-1:0]   pair_bc,
  output logic [PW-1:0]   pair_de,
  output logic [PW-1:0]   pair_hl,
  output logic [PW-1:0]   pair_sp
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  logic [NPAIR-1:0][PW-1:0] pr_q;
  logic                     pw_en, swap_en, lo_en, hi_en;
  logic [SELW-1:0]          pw_sel;
  logic [PW-1:0]            pw_val;
  logic [DW-1:0]            byte_val;

  pxu_seq #(.DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .start       (start),
    .op_i        (op),
    .psel_i      (psel),
    .imm_i       (imm),
    .acc_i       (acc_in),
    .mem_rdata   (mem_rdata),
    .pr_q        (pr_q),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .done        (done),
    .acc_ld_we   (acc_ld_we),
    .acc_ld_data (acc_ld_data),
    .cy_we       (cy_we),
    .cy_val      (cy_val),
    .pw_en       (pw_en),
    .pw_sel      (pw_sel),
    .pw_val      (pw_val),
    .swap_en     (swap_en),
    .lo_en       (lo_en),
    .hi_en       (hi_en),
    .byte_val    (byte_val)
  );

  pxu_bank #(.DW(DW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .pw_en    (pw_en),
    .pw_sel   (pw_sel),
    .pw_val   (pw_val),
    .swap_en  (swap_en),
    .lo_en    (lo_en),
    .hi_en    (hi_en),
    .byte_val (byte_val),
    .pr_q     (pr_q)
  );

  assign pair_bc = pr_q[PR_BC];
  assign pair_de = pr_q[PR_DE];
  assign pair_hl = pr_q[PR_HL];
  assign pair_sp = pr_q[PR_SP];

  // R1: strobes stay low while reset is held
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_s_n |-> !mem_we && !mem_re && !done && !cy_we && !acc_ld_we);

endmodule

// File: tb/pair_xfer_unit_bench.sv
module pair_xfer_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  op;
  logic [1:0]  psel;
  logic [15:0] imm;
  logic [7:0]  acc_in;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we, mem_re, done, acc_ld_we, cy_we, cy_val;
  logic [7:0]  acc_ld_data;
  logic [15:0] pair_bc, pair_de, pair_hl, pair_sp;

  pair_xfer_unit u_pair_xfer_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .psel(psel), .imm(imm),
    .acc_in(acc_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .done(done),
    .acc_ld_we(acc_ld_we), .acc_ld_data(acc_ld_data), .cy_we(cy_we),
    .cy_val(cy_val), .pair_bc(pair_bc), .pair_de(pair_de),
    .pair_hl(pair_hl), .pair_sp(pair_sp)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  // memory model: read byte is a fixed function of the address
  function automatic logic [7:0] mfun(input logic [15:0] a);
    return a[15:8] ^ {a[6:0], a[7]} ^ 8'h3C;
  endfunction

  logic [15:0] a_lat;
  always @(negedge clk) a_lat <= mem_addr;
  always @(posedge clk) mem_rdata <= mfun(a_lat);

  logic [15:0] wa [64];
  logic [7:0]  wd [64];
  int          wr_n = 0;
  int          rd_n = 0;
  always @(negedge clk) begin
    if (mem_we) begin
      wa[wr_n % 64] <= mem_addr;
      wd[wr_n % 64] <= mem_wdata;
      wr_n <= wr_n + 1;
    end
    if (mem_re) rd_n <= rd_n + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nerr = nerr + 1;
      $display("FAIL R11 watchdog act=%0d exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    nchk = nchk + 1;
    if (act !== exp_v) begin
      nerr = nerr + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp_v);
    end
  endtask

  logic [15:0] ex [4];

  function automatic int lat_exp(input logic [3:0] o, input logic [1:0] s);
    case (o)
      4'd1:    return 3;
      4'd2:    return 4;
      4'd3:    return (s < 2) ? 3 : 2;
      default: return 2;
    endcase
  endfunction

  task automatic run_op(input logic [3:0] o, input logic [1:0] s, input logic [15:0] v,
                        input logic [7:0] a, input bit hold);
    int          wr0, rd0, n, ewr, erd;
    bit          ok;
    string       tag;
    logic [16:0] sum;
    logic        ecy;
    logic [7:0]  eacc;
    logic [15:0] hl0, tmp;
    ok   = (s < 2);
    wr0  = wr_n;
    rd0  = rd_n;
    hl0  = ex[2];
    ecy  = 1'b0;
    eacc = 8'h00;
    ewr  = 0;
    erd  = 0;
    case (o)
      4'd0: begin tag = "R2"; ex[s] = v; end
      4'd1: begin tag = "R3"; ewr = 2; end
      4'd2: begin tag = "R4"; erd = 2; ex[2] = {mfun(v + 16'd1), mfun(v)}; end
      4'd3: begin tag = ok ? "R5" : "R7"; erd = ok ? 1 : 0; eacc = mfun(ex[s]); end
      4'd4: begin tag = ok ? "R6" : "R7"; ewr = ok ? 1 : 0; end
      4'd5: begin tag = "R8"; tmp = ex[1]; ex[1] = ex[2]; ex[2] = tmp; end
      4'd6: begin tag = "R9"; sum = {1'b0, ex[2]} + {1'b0, ex[s]}; ex[2] = sum[15:0]; ecy = sum[16]; end
      4'd7: begin tag = "R10"; ex[s] = ex[s] + 16'd1; end
      4'd8: begin tag = "R10"; ex[s] = ex[s] - 16'd1; end
      default: tag = "R12";
    endcase
    if (hold) tag = "R12";

    @(negedge clk);
    start = 1'b1; op = o; psel = s; imm = v; acc_in = a;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 1) begin
        if (hold) begin op = 4'd0; psel = 2'd0; imm = 16'hDEAD; acc_in = 8'h00; end
        else start = 1'b0;
      end
    end while (!done && n < 30);
    start = 1'b0;

    chk("R11", 64'(n), 64'(lat_exp(o, s)));
    chk((o == 4'd6) ? "R9" : "R10", 64'(cy_we), 64'(o == 4'd6));
    if (o == 4'd6) chk("R9", 64'(cy_val), 64'(ecy));
    chk(tag, 64'(acc_ld_we), 64'((o == 4'd3) && ok));
    if ((o == 4'd3) && ok) chk("R5", 64'(acc_ld_data), 64'(eacc));
    chk(tag, 64'(wr_n - wr0), 64'(ewr));
    chk(tag, 64'(rd_n - rd0), 64'(erd));
    if ((o == 4'd1) && (wr_n - wr0 == 2)) begin
      chk("R3", {32'h0, wa[wr0 % 64], 8'h0, wd[wr0 % 64]}, {32'h0, v, 8'h0, hl0[7:0]});
      chk("R3", {32'h0, wa[(wr0 + 1) % 64], 8'h0, wd[(wr0 + 1) % 64]},
          {32'h0, v + 16'd1, 8'h0, hl0[15:8]});
    end
    if ((o == 4'd4) && ok && (wr_n - wr0 == 1))
      chk("R6", {40'h0, wa[wr0 % 64], wd[wr0 % 64]}, {40'h0, ex[s], a});
    @(negedge clk);
    chk("R11", 64'(done), 64'd0);
    chk(tag, {pair_bc, pair_de, pair_hl, pair_sp}, {ex[0], ex[1], ex[2], ex[3]});
  endtask

  logic [15:0] vals [7];
  logic [15:0] dh [4];
  logic [15:0] dp [4];
  logic [15:0] dadr [4];

  initial begin
    vals = '{16'h0000, 16'h0001, 16'h00FF, 16'h0100, 16'h7FFF, 16'h8000, 16'hFFFF};
    dh   = '{16'h2001, 16'hFFFF, 16'h8000, 16'h1C15};
    dp   = '{16'h2000, 16'h0001, 16'h8000, 16'h5AB7};
    dadr = '{16'h0000, 16'h1234, 16'h80FF, 16'hFFFF};
    for (int i = 0; i < 4; i++) ex[i] = 16'h0000;
    start = 1'b0; op = '0; psel = '0; imm = '0; acc_in = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {60'h0, done, mem_we, mem_re, cy_we}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", {pair_bc, pair_de, pair_hl, pair_sp}, 64'h0);
    chk("R1", {61'h0, acc_ld_we, mem_we, done}, 64'h0);

    // R2 constant loads on every pair
    for (int p = 0; p < 4; p++) begin
      run_op(4'd0, 2'(p), 16'h1100 * 16'(p + 1) + 16'h0011, 8'h00, 1'b0);
      run_op(4'd0, 2'(p), 16'hA5C3 ^ 16'(p), 8'h00, 1'b0);
    end

    // R10 step sweep on every pair, SP included
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 7; k++) begin
        run_op(4'd0, 2'(p), vals[k], 8'h00, 1'b0);
        run_op(4'd7, 2'(p), 16'h0, 8'h00, 1'b0);
        run_op(4'd0, 2'(p), vals[k], 8'h00, 1'b0);
        run_op(4'd8, 2'(p), 16'h0, 8'h00, 1'b0);
      end

    // R9 pair add with and without carry
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 4; k++) begin
        if (p != 2) run_op(4'd0, 2'(p), dp[k], 8'h00, 1'b0);
        run_op(4'd0, 2'd2, dh[k], 8'h00, 1'b0);
        run_op(4'd6, 2'(p), 16'h0, 8'h00, 1'b0);
      end

    // R8 exchange
    run_op(4'd0, 2'd2, 16'h4500, 8'h00, 1'b0);
    run_op(4'd0, 2'd1, 16'h4531, 8'h00, 1'b0);
    run_op(4'd5, 2'd3, 16'h0, 8'h00, 1'b0);
    chk("R8", {32'h0, pair_hl, pair_de}, {32'h0, 16'h4531, 16'h4500});
    run_op(4'd5, 2'd0, 16'h0, 8'h00, 1'b0);

    // R3 and R4 direct transfers, including the FFFFh wrap
    for (int k = 0; k < 4; k++) begin
      run_op(4'd0, 2'd2, 16'h9845 + 16'(k * 16'h0111), 8'h00, 1'b0);
      run_op(4'd1, 2'd0, dadr[k], 8'h00, 1'b0);
      run_op(4'd2, 2'd0, dadr[k], 8'h00, 1'b0);
    end

    // R5 R6 R7 indirect forms on every select
    for (int p = 0; p < 4; p++) begin
      run_op(4'd0, 2'(p), 16'h3200 + 16'(p * 16'h0401), 8'h00, 1'b0);
      run_op(4'd3, 2'(p), 16'h0, 8'h00, 1'b0);
      run_op(4'd4, 2'(p), 16'h0, 8'h99 ^ 8'(p), 1'b0);
    end

    // R12 unused codes
    for (int c = 9; c < 16; c++) run_op(4'(c), 2'(c % 4), 16'h5555, 8'h00, 1'b0);

    // R12 competing command held on start while busy
    run_op(4'd0, 2'd0, 16'h1357, 8'h00, 1'b0);
    run_op(4'd2, 2'd0, 16'h4000, 8'h00, 1'b1);
    run_op(4'd4, 2'd1, 16'h0, 8'h6B, 1'b1);
    run_op(4'd6, 2'd3, 16'h0, 8'h00, 1'b1);
    chk("R12", 64'(pair_bc), 64'h1357);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule